// File: doc/BRIEF.md
# PWM Timer Fault Reaction and Output Park Unit

This block sits beside a small up-counting PWM timer. It watches one fault line and reacts in the way software has picked. It can freeze the counter on the spot, or let the counter run until it next reaches zero and then hold it there. It can also do nothing more than raise an interrupt flag, or it can disregard the line. The fault line is level-sensitive, and a polarity bit sets which level counts as active. Both the fault line and a debug-halt line pass through a two-stage synchronizer before any logic uses them.

A second function overrides the three PWM channel outputs and their three complementary outputs. When the selected cause is present (fault, debug halt, or either), each of the six lines is driven to its own programmed level. Once the cause goes away, the raw channel values pass through again. The timer counter itself is included so that the stop and hold behaviour can be observed at the ports. It runs in periodic, single-shot or up-down mode.

Top module: `pwm_fault_park`

## Requirements
- R1: After reset the fault flag is 0, the counter mode is 0, the count is 0, and with no park cause active each output equals its raw input.
- R2: Counter mode encoding. 0 means stopped, and the count holds. 1 counts 0..top and wraps to 0. 2 counts up to top, then goes to 0 with the mode becoming 0. 3 counts up to top and back down to 0, over and over. A mode write takes effect at the next clock edge, and counting starts from the edge after that.
- R3: With fault reaction 0 the fault line has no effect: the flag stays 0, the mode is unchanged and no fault park occurs.
- R4: The fault is active when the line equals the polarity bit (1 = active high, 0 = active low). With reaction 1, 2 or 3 and a running counter, the flag reads 1 on the third clock edge after the line becomes active.
- R5: Reaction 1 (immediate stop) sets the counter mode to 0 on the same edge that sets the flag, and the count then holds. Only a mode write restarts the counter.
- R6: While the counter mode is 0, an active fault does not set a cleared flag.
- R7: Reaction 2 (stop at zero) holds the count at 0, with the mode kept, whenever the count is 0 and the flag is set or the fault is active. After the flag is cleared and the fault is inactive, counting resumes one edge after the clear in the kept mode.
- R8: Under reaction 2, if the flag is cleared and the fault is inactive before the count reaches 0, counting continues through zero without a stop.
- R9: Reaction 3 only sets the flag; the counter keeps running in its mode.
- R10: The flag is cleared by a one-cycle write of 1 to the clear input. A set in the same cycle as a clear wins.
- R11: Park select field (bits 1:0 of the park configuration) has this encoding: 0 = never, 1 = on fault, 2 = on debug halt, 3 = on either. While parked, output n is driven to configuration bit 2+2n and its complement to bit 3+2n.
- R12: Park takes effect on the second clock edge after the cause line changes and is released on the second edge after it goes away. There is no further delay, because the override is combinational on the synchronized cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_mode | input | 2 | Fault reaction select (0 off, 1 immediate, 2 at zero, 3 flag only) |
| fault_pol | input | 1 | Fault active level |
| park_cfg | input | 8 | Park select in [1:0], output levels in [7:2] |
| mode_wr_en | input | 1 | Counter mode write strobe |
| mode_wr_data | input | 2 | Counter mode value to write |
| flag_clr | input | 1 | Write-one-to-clear for the fault flag |
| cnt_top | input | 8 | Counter top value (at least 1) |
| fault_in | input | 1 | Asynchronous fault line |
| dbg_halt | input | 1 | Asynchronous debug-halt line |
| raw_out | input | 3 | Raw channel outputs |
| raw_out_n | input | 3 | Raw complementary outputs |
| pwm_out | output | 3 | Final channel outputs |
| pwm_out_n | output | 3 | Final complementary outputs |
| fault_flag | output | 1 | Raw fault interrupt flag |
| cnt_mode | output | 2 | Current counter mode |
| cnt_val | output | 8 | Current count |

## Verification
The hardest case to reach is the stop-at-zero window. A fault must arrive while the count is away from zero, and the bench must then decide whether the flag is cleared before the count wraps. The stimulus follows the count at the port until it reaches a chosen value and raises the top value so that the window is long. It then either clears the flag in time or keeps the fault asserted through the wrap, and watches whether the count passes zero or sticks there. The set-versus-clear collision is reached by holding the fault active while the clear pulse is issued.

// File: rtl/pfp_pkg.sv
`timescale 1ns/1ps
package pfp_pkg;

  typedef enum logic [1:0] {
    FR_OFF  = 2'd0,
    FR_HALT = 2'd1,
    FR_ZERO = 2'd2,
    FR_FLAG = 2'd3
  } fault_react_e;

  typedef enum logic [1:0] {
    CM_OFF  = 2'd0,
    CM_WRAP = 2'd1,
    CM_SHOT = 2'd2,
    CM_UPDN = 2'd3
  } cnt_mode_e;

  // park select: bit 0 enables fault cause, bit 1 enables debug cause
  function automatic logic park_wanted(input logic [1:0] sel,
                                       input logic flt,
                                       input logic dbg);
    return (sel[0] & flt) | (sel[1] & dbg);
  endfunction

  // position of a park level bit inside the park configuration word
  function automatic int park_bit(input int ch, input bit comp);
    return 2 + 2 * ch + (comp ? 1 : 0);
  endfunction

  // active fault level from the synchronized line and its polarity
  function automatic logic fault_level(input logic line, input logic pol);
    return pol ? line : ~line;
  endfunction

endpackage

// File: rtl/pfp_sync.sv
`timescale 1ns/1ps
module pfp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pfp_counter.sv
`timescale 1ns/1ps
module pfp_counter import pfp_pkg::*; #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr_en,
  input  logic [1:0]    mode_wr_data,
  input  logic          hw_stop,
  input  logic          hold,
  input  logic [CW-1:0] top,
  output logic [1:0]    mode,
  output logic [CW-1:0] cnt,
  output logic          shot_done
);

  logic          dir_dn;
  logic          adv;
  logic [CW:0]   nxt;

  // returns {direction, count} for the next edge
  function automatic logic [CW:0] next_state(input logic [1:0]    m,
                                             input logic [CW-1:0] c,
                                             input logic          d,
                                             input logic [CW-1:0] t);
    logic [CW:0] r;
    r = {d, c};
    case (cnt_mode_e'(m))
      CM_WRAP, CM_SHOT: begin
        if (c >= t) r = '0;
        else        r = {1'b0, c + CW'(1)};
      end
      CM_UPDN: begin
        if (t == '0)      r = '0;
        else if (!d)      r = (c >= t) ? {1'b1, c - CW'(1)} : {1'b0, c + CW'(1)};
        else              r = (c == '0) ? {1'b0, c + CW'(1)} : {1'b1, c - CW'(1)};
      end
      default: r = {d, c};
    endcase
    return r;
  endfunction

  assign adv       = (mode != CM_OFF) && !hold;
  assign nxt       = next_state(mode, cnt, dir_dn, top);
  assign shot_done = adv && (mode == CM_SHOT) && (cnt >= top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= CM_OFF;
      cnt    <= '0;
      dir_dn <= 1'b0;
    end else begin
      if (hw_stop || shot_done) mode <= CM_OFF;
      else if (mode_wr_en)      mode <= mode_wr_data;

      if (mode_wr_en) dir_dn <= 1'b0;
      else if (adv)   dir_dn <= nxt[CW];

      if (adv) cnt <= nxt[CW-1:0];
    end
  end

endmodule

// File: rtl/pfp_fault.sv
`timescale 1ns/1ps
module pfp_fault import pfp_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fault_s,
  input  logic       pol,
  input  logic [1:0] fmode,
  input  logic [1:0] cmode,
  input  logic       cnt_zero,
  input  logic       flag_clr,
  output logic       flag,
  output logic       flag_set,
  output logic       hw_stop,
  output logic       zero_hold,
  output logic       fault_act
);

  logic running;

  assign fault_act = fault_level(fault_s, pol) && (fmode != FR_OFF);
  assign running   = (cmode != CM_OFF);
  assign flag_set  = fault_act && running;
  assign hw_stop   = flag_set && (fmode == FR_HALT);
  assign zero_hold = (fmode == FR_ZERO) && running && cnt_zero && (flag || fault_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (flag_set) flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

endmodule

// File: rtl/pfp_park.sv
`timescale 1ns/1ps
module pfp_park import pfp_pkg::*; #(
  parameter int NCH = 3,
  localparam int PCW = 2 + 2 * NCH
) (
  input  logic [PCW-1:0] cfg,
  input  logic           cause_fault,
  input  logic           cause_dbg,
  input  logic [NCH-1:0] raw,
  input  logic [NCH-1:0] raw_n,
  output logic [NCH-1:0] out,
  output logic [NCH-1:0] out_n,
  output logic           parked
);

  assign parked = park_wanted(cfg[1:0], cause_fault, cause_dbg);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int PB = park_bit(ch, 1'b0);
    localparam int NB = park_bit(ch, 1'b1);
    assign out[ch]   = parked ? cfg[PB] : raw[ch];
    assign out_n[ch] = parked ? cfg[NB] : raw_n[ch];
  end

endmodule

// File: rtl/pwm_fault_park.sv
`timescale 1ns/1ps
module pwm_fault_park import pfp_pkg::*; #(
  parameter int NCH         = 3,
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PCW = 2 + 2 * NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     fault_mode,
  input  logic           fault_pol,
  input  logic [PCW-1:0] park_cfg,
  input  logic           mode_wr_en,
  input  logic [1:0]     mode_wr_data,
  input  logic           flag_clr,
  input  logic [CW-1:0]  cnt_top,
  input  logic           fault_in,
  input  logic           dbg_halt,
  input  logic [NCH-1:0] raw_out,
  input  logic [NCH-1:0] raw_out_n,
  output logic [NCH-1:0] pwm_out,
  output logic [NCH-1:0] pwm_out_n,
  output logic           fault_flag,
  output logic [1:0]     cnt_mode,
  output logic [CW-1:0]  cnt_val
);

  logic [1:0] sync_q;
  logic       fault_sync;
  logic       dbg_sync;
  logic       fault_act;
  logic       flag_set;
  logic       hw_stop;
  logic       zero_hold;
  logic       shot_done;
  logic       parked;

  pfp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({dbg_halt, fault_in}),
    .q     (sync_q)
  );

  assign fault_sync = sync_q[0];
  assign dbg_sync   = sync_q[1];

  pfp_fault u_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_s   (fault_sync),
    .pol       (fault_pol),
    .fmode     (fault_mode),
    .cmode     (cnt_mode),
    .cnt_zero  (cnt_val == '0),
    .flag_clr  (flag_clr),
    .flag      (fault_flag),
    .flag_set  (flag_set),
    .hw_stop   (hw_stop),
    .zero_hold (zero_hold),
    .fault_act (fault_act)
  );

  pfp_counter #(.CW(CW)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_wr_en   (mode_wr_en),
    .mode_wr_data (mode_wr_data),
    .hw_stop      (hw_stop),
    .hold         (zero_hold),
    .top          (cnt_top),
    .mode         (cnt_mode),
    .cnt          (cnt_val),
    .shot_done    (shot_done)
  );

  pfp_park #(.NCH(NCH)) u_park (
    .cfg         (park_cfg),
    .cause_fault (fault_act),
    .cause_dbg   (dbg_sync),
    .raw         (raw_out),
    .raw_n       (raw_out_n),
    .out         (pwm_out),
    .out_n       (pwm_out_n),
    .parked      (parked)
  );

endmodule

// File: rtl/pfp_chk.sv
`timescale 1ns/1ps
module pfp_chk #(
  parameter int NCH = 3,
  parameter int CW  = 8,
  localparam int PCW = 2 + 2 * NCH
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     fault_mode,
  input logic [PCW-1:0] park_cfg,
  input logic           flag_clr,
  input logic [NCH-1:0] pwm_out,
  input logic [NCH-1:0] pwm_out_n,
  input logic           fault_flag,
  input logic [1:0]     cnt_mode,
  input logic [CW-1:0]  cnt_val,
  input logic           flag_set,
  input logic           zero_hold,
  input logic           fault_act,
  input logic           dbg_sync,
  input logic           parked
);

  logic [NCH-1:0] lvl_o, lvl_n;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      lvl_o[i] = park_cfg[2 + 2*i];
      lvl_n[i] = park_cfg[3 + 2*i];
    end
  end

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> fault_flag);

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !flag_set) |=> !fault_flag);

  // R5
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_mode == 2'd1 && flag_set) |=> (cnt_mode == 2'd0));

  // R6
  idle_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode == 2'd0) |-> !flag_set);

  // R3
  off_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_mode == 2'd0) |-> (!flag_set && !fault_act));

  // R7
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hold |=> (cnt_val == '0));

  // R2
  off_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode == 2'd0) |=> $stable(cnt_val));

  // R11
  park_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parked |-> (pwm_out == lvl_o && pwm_out_n == lvl_n));

  // R12
  park_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parked |-> ((park_cfg[0] && fault_act) || (park_cfg[1] && dbg_sync)));

endmodule

bind pwm_fault_park pfp_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fault_mode (fault_mode),
  .park_cfg   (park_cfg),
  .flag_clr   (flag_clr),
  .pwm_out    (pwm_out),
  .pwm_out_n  (pwm_out_n),
  .fault_flag (fault_flag),
  .cnt_mode   (cnt_mode),
  .cnt_val    (cnt_val),
  .flag_set   (flag_set),
  .zero_hold  (zero_hold),
  .fault_act  (fault_act),
  .dbg_sync   (dbg_sync),
  .parked     (parked)
);

// File: tb/pwm_fault_park_bench.sv
`timescale 1ns/1ps
module pwm_fault_park_bench;

  localparam int NCH = 3;
  localparam int CW  = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [1:0]     fault_mode;
  logic           fault_pol;
  logic [7:0]     park_cfg;
  logic           mode_wr_en;
  logic [1:0]     mode_wr_data;
  logic           flag_clr;
  logic [CW-1:0]  cnt_top;
  logic           fault_in;
  logic           dbg_halt;
  logic [NCH-1:0] raw_out, raw_out_n;
  logic [NCH-1:0] pwm_out, pwm_out_n;
  logic           fault_flag;
  logic [1:0]     cnt_mode;
  logic [CW-1:0]  cnt_val;

  pwm_fault_park #(.NCH(NCH), .CW(CW)) u_pwm_fault_park (
    .clk(clk), .rst_n(rst_n), .fault_mode(fault_mode), .fault_pol(fault_pol),
    .park_cfg(park_cfg), .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
    .flag_clr(flag_clr), .cnt_top(cnt_top), .fault_in(fault_in), .dbg_halt(dbg_halt),
    .raw_out(raw_out), .raw_out_n(raw_out_n), .pwm_out(pwm_out), .pwm_out_n(pwm_out_n),
    .fault_flag(fault_flag), .cnt_mode(cnt_mode), .cnt_val(cnt_val)
  );

  always #5 clk = ~clk;

  typedef struct { int sel; int exp; string req; } exp_t;
  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam int S_OUT = 0, S_OUTN = 1, S_FLAG = 2, S_MODE = 3, S_CNT = 4;

  function automatic int observe(int sel);
    case (sel)
      S_OUT:  return int'(pwm_out);
      S_OUTN: return int'(pwm_out_n);
      S_FLAG: return int'(fault_flag);
      S_MODE: return int'(cnt_mode);
      default: return int'(cnt_val);
    endcase
  endfunction

  // monitor: pops expected items and compares them at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t it;
      int got;
      it  = exp_q.pop_front();
      got = observe(it.sel);
      checks++;
      if (got != it.exp) begin
        failures++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, got, it.exp);
      end
    end
  end

  task automatic push(int sel, int exp, string req);
    exp_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic flush();
    @(negedge clk);
    #1;
  endtask

  task automatic write_mode(logic [1:0] m);
    mode_wr_en = 1'b1; mode_wr_data = m;
    step(1);
    mode_wr_en = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
  endtask

  task automatic wait_cnt(int v, string req);
    for (int i = 0; i < 400; i++) begin
      if (int'(cnt_val) == v) return;
      step(1);
    end
    checks++; failures++;
    $display("FAIL %s wait for count actual=%0d expected=%0d", req, cnt_val, v);
  endtask

  function automatic int wrap_next(int c, int t);
    return (c >= t) ? 0 : c + 1;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    rst_n = 1'b0; fault_mode = 2'd0; fault_pol = 1'b1; park_cfg = 8'h00;
    mode_wr_en = 1'b0; mode_wr_data = 2'd0; flag_clr = 1'b0; cnt_top = 8'd3;
    fault_in = 1'b0; dbg_halt = 1'b0; raw_out = 3'b011; raw_out_n = 3'b100;
    step(3);
    rst_n = 1'b1;
    // R1 reset state
    push(S_FLAG, 0, "R1"); push(S_MODE, 0, "R1"); push(S_CNT, 0, "R1");
    push(S_OUT, 3, "R1"); push(S_OUTN, 4, "R1");
    flush();

    // R2 single-shot to top 3
    write_mode(2'd2);
    push(S_MODE, 2, "R2"); push(S_CNT, 0, "R2");
    step(3); push(S_CNT, 3, "R2"); push(S_MODE, 2, "R2");
    step(1); push(S_CNT, 0, "R2"); push(S_MODE, 0, "R2");
    step(2); push(S_CNT, 0, "R2");
    flush();

    // R2 up-down
    write_mode(2'd3);
    push(S_MODE, 3, "R2"); push(S_CNT, 0, "R2");
    step(3); push(S_CNT, 3, "R2");
    step(1); push(S_CNT, 2, "R2");
    step(2); push(S_CNT, 0, "R2");
    step(1); push(S_CNT, 1, "R2");
    flush();

    // R2 periodic wrap, top 5 (the write edge still counts up-down: 1 -> 2)
    cnt_top = 8'd5;
    write_mode(2'd1);
    push(S_MODE, 1, "R2"); push(S_CNT, 2, "R2");
    step(3); push(S_CNT, 5, "R2");
    step(1); push(S_CNT, 0, "R2");
    step(1); push(S_CNT, 1, "R2");
    flush();

    // R3 fault reaction off
    park_cfg = 8'b1110_0101; raw_out = 3'b010; raw_out_n = 3'b101;
    fault_in = 1'b1;
    step(4);
    push(S_FLAG, 0, "R3"); push(S_MODE, 1, "R3"); push(S_OUT, 2, "R3"); push(S_OUTN, 5, "R3");
    flush();
    fault_in = 1'b0;
    step(3);

    // R9 / R4 / R11 / R12 flag-only reaction with park on fault
    fault_mode = 2'd3;
    fault_in = 1'b1;
    step(2);
    push(S_FLAG, 0, "R4"); push(S_OUT, 5, "R12"); push(S_OUTN, 6, "R11");
    step(1);
    push(S_FLAG, 1, "R4"); push(S_MODE, 1, "R9");
    flush();
    fault_in = 1'b0;
    step(1); push(S_OUT, 5, "R12");
    step(1); push(S_OUT, 2, "R12"); push(S_OUTN, 5, "R12");
    flush();

    // R10 set wins over clear
    fault_in = 1'b1;
    step(2);
    clear_flag();
    push(S_FLAG, 1, "R10");
    flush();
    fault_in = 1'b0;
    step(3);
    clear_flag();
    push(S_FLAG, 0, "R10");
    flush();

    // R11 park select encodings
    dbg_halt = 1'b1;
    step(3); push(S_OUT, 2, "R11");
    flush();
    park_cfg[1:0] = 2'b10;
    step(1); push(S_OUT, 5, "R11"); push(S_OUTN, 6, "R11");
    flush();
    dbg_halt = 1'b0; park_cfg[1:0] = 2'b11;
    step(3); push(S_OUT, 2, "R11");
    flush();
    fault_in = 1'b1;
    step(3); push(S_OUT, 5, "R11");
    flush();
    fault_in = 1'b0;
    step(3); push(S_OUT, 2, "R11");
    flush();
    park_cfg[1:0] = 2'b00; fault_in = 1'b1; dbg_halt = 1'b1;
    step(3); push(S_OUT, 2, "R11"); push(S_OUTN, 5, "R11");
    flush();
    fault_in = 1'b0; dbg_halt = 1'b0;
    step(3);
    clear_flag();

    // R5 immediate stop, R6 no set while stopped
    fault_mode = 2'd1;
    fault_in = 1'b1;
    step(2); push(S_MODE, 1, "R5");
    step(1); push(S_MODE, 0, "R5"); push(S_FLAG, 1, "R5");
    c0 = int'(cnt_val);
    step(3); push(S_CNT, c0, "R5"); push(S_MODE, 0, "R5");
    flush();
    fault_in = 1'b0;
    step(3);
    clear_flag();
    push(S_FLAG, 0, "R6");
    flush();
    fault_in = 1'b1;
    step(4); push(S_FLAG, 0, "R6"); push(S_MODE, 0, "R6");
    flush();
    fault_in = 1'b0;
    step(3);
    write_mode(2'd1);
    push(S_MODE, 1, "R5"); push(S_CNT, c0, "R5");
    step(1); push(S_CNT, wrap_next(c0, 5), "R5");
    flush();

    // R8 stop-at-zero cancelled in time
    cnt_top = 8'd40; fault_mode = 2'd2;
    wait_cnt(2, "R8");
    fault_in = 1'b1;
    step(3); push(S_FLAG, 1, "R8");
    flush();
    fault_in = 1'b0;
    step(3);
    clear_flag();
    push(S_FLAG, 0, "R8");
    flush();
    wait_cnt(0, "R8");
    step(2); push(S_CNT, 2, "R8"); push(S_MODE, 1, "R8");
    flush();

    // R7 stop at zero and resume
    wait_cnt(2, "R7");
    fault_in = 1'b1;
    step(3); push(S_FLAG, 1, "R7");
    flush();
    wait_cnt(0, "R7");
    step(3); push(S_CNT, 0, "R7"); push(S_MODE, 1, "R7");
    flush();
    fault_in = 1'b0;
    step(3); push(S_CNT, 0, "R7"); push(S_FLAG, 1, "R7");
    flush();
    clear_flag();
    push(S_FLAG, 0, "R7"); push(S_CNT, 0, "R7");
    step(1); push(S_CNT, 1, "R7");
    step(1); push(S_CNT, 2, "R7"); push(S_MODE, 1, "R7");
    flush();

    // R4 active-low polarity
    fault_mode = 2'd3; fault_in = 1'b1; fault_pol = 1'b0;
    step(3);
    clear_flag();
    step(3); push(S_FLAG, 0, "R4");
    flush();
    fault_in = 1'b0;
    step(2); push(S_FLAG, 0, "R4");
    step(1); push(S_FLAG, 1, "R4");
    flush();
    step(1);

    done = 1;
    summary();
    $finish;
  end

endmodule